// File: doc/BRIEF.md
# Programmable memory window attribute decoder

This block sits in a system controller on the path of every memory cycle. It holds two programmable address windows. Each window has a start address, a 4-bit size code and three attribute bits that act independently. The attributes are: cacheable, punch a hole in local DRAM, and force the cycle to the local bus. For each memory cycle the block checks the address against both windows and merges the attributes of the windows that hit. It then steers the cycle to exactly one target: the local-bus slave, local DRAM, ROM or the expansion bus.

A window compares A31 together with A27 down to its size boundary. A30:28 never take part, so every window repeats at 256MB intervals. The size codes 0 to 11 select 64K, 128K, 256K, 512K, 1M, 2M, 4M, 8M, 16M, 32M, 64M and 128M, each code doubling the previous size. Codes 12 to 15 turn the window off.

The caller provides, for each cycle, whether the address lies in DRAM, whether it lies in a ROM range, and whether a local-bus slave claims it. A register write port loads one window at a time. All outputs are registered. A cycle presented at a clock edge shows its target after that edge. The output register holds a target state, one of IDLE, DRAM, LBUS, ROM and EXP, and it is reloaded on every clock. From any state the register goes to IDLE when no cycle is presented, to LBUS on a claim or a forced window, to DRAM on an unholed low DRAM hit, to ROM on a ROM hit, and to EXP otherwise.

Top module: `memwin_decoder`

## Requirements
- R1: After reset both windows hold all zeros: start 0, size code 0 and no attribute. A cycle therefore steers exactly as it would with no windows present.
- R2: A window with size code s (0..11) covers 64K·2^s bytes. It hits when A31 equals start bit 12 and address bits 27 down to 16+s equal start bits 11 down to s. Start bit 12 holds A31 and start bits 11:0 hold A27:16. Address bits below the size boundary are never compared.
- R3: Address bits 30:28 are ignored by the window compare, so a window also hits at every 256MB alias that has the same A31.
- R4: Size codes 12 to 15 disable the window: it never hits.
- R5: The hole attribute (attribute bit 1) of a hitting window stops the DRAM target from being chosen. When the caller reports no DRAM hit, the hole attribute changes nothing.
- R6: The force attribute (attribute bit 2) of a hitting window sends the cycle to the local bus, even when the address hits DRAM or ROM.
- R7: The cacheable output is 1 for a presented cycle exactly when at least one hitting window has attribute bit 0 set. The attributes of two hitting windows combine by OR.
- R8: Target priority, highest first: local bus (claim or force), DRAM (hit, A31 = 0, no hole), ROM (ROM hit), expansion bus. A presented cycle raises exactly one target output. A cycle slot with valid low raises none and leaves cacheable and the ROM select at 0.
- R9: When a local-bus claim and a ROM hit arrive together, the ROM chip select stays asserted and the expansion-bus strobe enable stays low. The ROM chip select is asserted for every ROM hit that is not steered to DRAM.
- R10: A cycle with A31 = 1 never selects DRAM.
- R11: All outputs are registered with one cycle of latency. A window write changes the decode of cycles sampled from the next clock edge onward, and a cycle sampled at the write's own edge still uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one window |
| cfg_sel | input | 1 | Index of the window written |
| cfg_start | input | 13 | Start address: bit 12 = A31, bits 11:0 = A27:16 |
| cfg_size | input | 4 | Size code (0..11 valid, 12..15 disable) |
| cfg_attr | input | 3 | Attributes: bit 0 cacheable, bit 1 hole, bit 2 force local |
| cyc_valid | input | 1 | A memory cycle is presented |
| cyc_addr | input | 32 | Cycle address |
| cyc_dram_hit | input | 1 | Address lies in populated local DRAM |
| cyc_rom_hit | input | 1 | Address lies in a ROM range |
| cyc_lb_claim | input | 1 | A local-bus slave claims the cycle |
| sel_dram | output | 1 | Cycle goes to local DRAM |
| sel_lbus | output | 1 | Cycle goes to the local-bus slave |
| sel_rom | output | 1 | Cycle goes to ROM |
| sel_exp | output | 1 | Cycle goes to the expansion bus (strobe enable) |
| rom_cs | output | 1 | ROM chip select |
| cacheable | output | 1 | Cycle may be cached |

## Verification
The assertions check the rules that hold on every cycle. Targets are one-hot for a presented cycle and absent otherwise. A claim always wins the local bus and keeps the expansion strobe off, and it leaves the ROM select up on a ROM hit. A31 = 1 and a missing DRAM hit never produce a DRAM select. Window geometry cannot be stated without the programmed settings, so only the bench's scenarios show it. Those scenarios cover the size boundaries, the 256MB aliases, the reserved codes, the merging of two windows and the one-edge delay of a write.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
    localparam int START_W    = 13;
    localparam int SIZE_W     = 4;
    localparam int ATTR_W     = 3;
    localparam int SIZE_CODES = 12;
    localparam int CMP_LO     = 16;

    localparam int ATTR_CACHE = 0;
    localparam int ATTR_HOLE  = 1;
    localparam int ATTR_FORCE = 2;

    typedef struct packed {
        logic [START_W-1:0] start;
        logic [SIZE_W-1:0]  size;
        logic [ATTR_W-1:0]  attr;
    } win_cfg_t;

    typedef enum logic [2:0] {
        TGT_IDLE,
        TGT_DRAM,
        TGT_LBUS,
        TGT_ROM,
        TGT_EXP
    } tgt_e;
endpackage

// File: rtl/memwin_regs.sv
module memwin_regs
    import memwin_pkg::*;
#(
    parameter int NUM_WIN = 2,
    localparam int SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [SEL_W-1:0]           sel,
    input  win_cfg_t                   wdata,
    output win_cfg_t [NUM_WIN-1:0]     cfg
);
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg[w] <= '0;
            end else if (we && (sel == SEL_W'(w))) begin
                cfg[w] <= wdata;
            end
        end
    end
endmodule

// File: rtl/memwin_match.sv
module memwin_match
    import memwin_pkg::*;
(
    input  win_cfg_t    cfg,
    input  logic [31:0] addr,
    output logic        hit
);
    localparam int CMP_N = START_W - 1;

    logic [CMP_N-1:0]   care;
    logic [START_W-1:0] key;
    logic               size_ok;

    always_comb begin
        for (int j = 0; j < CMP_N; j++) begin
            care[j] = (j >= int'(cfg.size));
        end
        key     = {addr[31], addr[CMP_LO+CMP_N-1:CMP_LO]};
        size_ok = (int'(cfg.size) < SIZE_CODES);
        hit     = size_ok && (((key ^ cfg.start) & {1'b1, care}) == '0);
    end
endmodule

// File: rtl/memwin_steer.sv
module memwin_steer
    import memwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_valid,
    input  logic              addr_high,
    input  logic              dram_hit,
    input  logic              rom_hit,
    input  logic              lb_claim,
    input  logic [ATTR_W-1:0] attr_any,
    output logic              sel_dram,
    output logic              sel_lbus,
    output logic              sel_rom,
    output logic              sel_exp,
    output logic              rom_cs,
    output logic              cacheable
);
    tgt_e tgt_q, tgt_d;
    logic rom_cs_q, rom_cs_d;
    logic cache_q, cache_d;

    always_comb begin
        if (!cyc_valid) begin
            tgt_d = TGT_IDLE;
        end else if (lb_claim || attr_any[ATTR_FORCE]) begin
            tgt_d = TGT_LBUS;
        end else if (dram_hit && !addr_high && !attr_any[ATTR_HOLE]) begin
            tgt_d = TGT_DRAM;
        end else if (rom_hit) begin
            tgt_d = TGT_ROM;
        end else begin
            tgt_d = TGT_EXP;
        end
        rom_cs_d = cyc_valid && rom_hit && (tgt_d != TGT_DRAM);
        cache_d  = cyc_valid && attr_any[ATTR_CACHE];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q    <= TGT_IDLE;
            rom_cs_q <= 1'b0;
            cache_q  <= 1'b0;
        end else begin
            tgt_q    <= tgt_d;
            rom_cs_q <= rom_cs_d;
            cache_q  <= cache_d;
        end
    end

    always_comb begin
        sel_dram  = 1'b0;
        sel_lbus  = 1'b0;
        sel_rom   = 1'b0;
        sel_exp   = 1'b0;
        rom_cs    = rom_cs_q;
        cacheable = cache_q;
        unique case (tgt_q)
            TGT_IDLE: ;
            TGT_DRAM: sel_dram = 1'b1;
            TGT_LBUS: sel_lbus = 1'b1;
            TGT_ROM:  sel_rom  = 1'b1;
            TGT_EXP:  sel_exp  = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/memwin_decoder.sv
module memwin_decoder
    import memwin_pkg::*;
#(
    parameter int NUM_WIN = 2,
    localparam int SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [12:0]        cfg_start,
    input  logic [3:0]         cfg_size,
    input  logic [2:0]         cfg_attr,
    input  logic               cyc_valid,
    input  logic [31:0]        cyc_addr,
    input  logic               cyc_dram_hit,
    input  logic               cyc_rom_hit,
    input  logic               cyc_lb_claim,
    output logic               sel_dram,
    output logic               sel_lbus,
    output logic               sel_rom,
    output logic               sel_exp,
    output logic               rom_cs,
    output logic               cacheable
);
    win_cfg_t                 wdata;
    win_cfg_t [NUM_WIN-1:0]   cfg;
    logic     [NUM_WIN-1:0]   hit;
    logic     [ATTR_W-1:0]    attr_any;

    assign wdata = '{start: cfg_start, size: cfg_size, attr: cfg_attr};

    memwin_regs #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (wdata),
        .cfg   (cfg)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
        memwin_match u_match (
            .cfg  (cfg[w]),
            .addr (cyc_addr),
            .hit  (hit[w])
        );
    end

    always_comb begin
        attr_any = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (hit[w]) begin
                attr_any = attr_any | cfg[w].attr;
            end
        end
    end

    memwin_steer u_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_valid (cyc_valid),
        .addr_high (cyc_addr[31]),
        .dram_hit  (cyc_dram_hit),
        .rom_hit   (cyc_rom_hit),
        .lb_claim  (cyc_lb_claim),
        .attr_any  (attr_any),
        .sel_dram  (sel_dram),
        .sel_lbus  (sel_lbus),
        .sel_rom   (sel_rom),
        .sel_exp   (sel_exp),
        .rom_cs    (rom_cs),
        .cacheable (cacheable)
    );
endmodule

// File: rtl/memwin_chk.sv
module memwin_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cyc_valid,
    input logic [31:0] cyc_addr,
    input logic        cyc_dram_hit,
    input logic        cyc_rom_hit,
    input logic        cyc_lb_claim,
    input logic        sel_dram,
    input logic        sel_lbus,
    input logic        sel_rom,
    input logic        sel_exp,
    input logic        rom_cs,
    input logic        cacheable
);
    a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_dram, sel_lbus, sel_rom, sel_exp}));

    a_r8_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |=> ($countones({sel_dram, sel_lbus, sel_rom, sel_exp}) == 1));

    a_r8_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid |=> !(sel_dram || sel_lbus || sel_rom || sel_exp || rom_cs || cacheable));

    a_r9_claim_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_lb_claim) |=> (sel_lbus && !sel_exp));

    a_r9_rom_cs_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_lb_claim && cyc_rom_hit) |=> rom_cs);

    a_r10_high_no_dram: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_addr[31]) |=> !sel_dram);

    a_r5_no_hit_no_dram: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !cyc_dram_hit) |=> !sel_dram);
endmodule

bind memwin_decoder memwin_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_valid    (cyc_valid),
    .cyc_addr     (cyc_addr),
    .cyc_dram_hit (cyc_dram_hit),
    .cyc_rom_hit  (cyc_rom_hit),
    .cyc_lb_claim (cyc_lb_claim),
    .sel_dram     (sel_dram),
    .sel_lbus     (sel_lbus),
    .sel_rom      (sel_rom),
    .sel_exp      (sel_exp),
    .rom_cs       (rom_cs),
    .cacheable    (cacheable)
);

// File: tb/memwin_decoder_tb.sv
`timescale 1ns/1ps
module memwin_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_sel = '0;
    logic [12:0] cfg_start = '0;
    logic [3:0]  cfg_size = '0;
    logic [2:0]  cfg_attr = '0;
    logic        cyc_valid = 1'b0;
    logic [31:0] cyc_addr = '0;
    logic        cyc_dram_hit = 1'b0;
    logic        cyc_rom_hit = 1'b0;
    logic        cyc_lb_claim = 1'b0;
    logic        sel_dram, sel_lbus, sel_rom, sel_exp, rom_cs, cacheable;

    int    checks = 0;
    int    failures = 0;
    int    cycles = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    logic [12:0] m_start [2];
    logic [3:0]  m_size  [2];
    logic [2:0]  m_attr  [2];
    logic [5:0]  expv = '0;

    always #2 clk = ~clk;

    memwin_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_start(cfg_start), .cfg_size(cfg_size), .cfg_attr(cfg_attr),
        .cyc_valid(cyc_valid), .cyc_addr(cyc_addr), .cyc_dram_hit(cyc_dram_hit),
        .cyc_rom_hit(cyc_rom_hit), .cyc_lb_claim(cyc_lb_claim),
        .sel_dram(sel_dram), .sel_lbus(sel_lbus), .sel_rom(sel_rom),
        .sel_exp(sel_exp), .rom_cs(rom_cs), .cacheable(cacheable)
    );

    function automatic bit win_hit(int w, logic [31:0] a);
        logic [31:0] span, mask, base;
        if (m_size[w] > 4'd11) return 1'b0;
        span = 32'h0001_0000 << m_size[w];
        mask = ~(span - 1) & 32'h8FFF_FFFF;
        base = {m_start[w][12], 3'b000, m_start[w][11:0], 16'h0000};
        return (a & mask) == (base & mask);
    endfunction

    // reference model: expected outputs for the cycle sampled at this edge
    always @(posedge clk) begin
        logic [2:0] at;
        logic       ed, el, er, ee, ec, ecache;
        if (!rst_n) begin
            expv = '0;
            for (int w = 0; w < 2; w++) begin
                m_start[w] = '0; m_size[w] = '0; m_attr[w] = '0;
            end
        end else begin
            at = '0;
            for (int w = 0; w < 2; w++) if (win_hit(w, cyc_addr)) at = at | m_attr[w];
            ed = 0; el = 0; er = 0; ee = 0;
            if (cyc_valid) begin
                if (cyc_lb_claim || at[2]) el = 1;
                else if (cyc_dram_hit && !cyc_addr[31] && !at[1]) ed = 1;
                else if (cyc_rom_hit) er = 1;
                else ee = 1;
            end
            ec     = cyc_valid && cyc_rom_hit && !ed;
            ecache = cyc_valid && at[0];
            expv   = {ed, el, er, ee, ec, ecache};
            if (cfg_we) begin
                m_start[cfg_sel] = cfg_start;
                m_size[cfg_sel]  = cfg_size;
                m_attr[cfg_sel]  = cfg_attr;
            end
        end
    end

    always @(negedge clk) begin
        logic [5:0] act;
        if (!done) begin
            cycles++;
            act = {sel_dram, sel_lbus, sel_rom, sel_exp, rom_cs, cacheable};
            checks++;
            if (act !== expv) begin
                failures++;
                $display("FAIL %s cycle %0d: outputs dram,lbus,rom,exp,romcs,cache actual=%b expected=%b",
                         cur_req, cycles, act, expv);
            end
            if (cycles > 100000) begin
                failures++;
                $display("FAIL watchdog: actual=hung expected=finished");
                done = 1'b1;
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    task automatic wr(input int w, input logic [12:0] st, input logic [3:0] sz, input logic [2:0] at);
        @(negedge clk);
        cfg_we = 1; cfg_sel = 1'(w); cfg_start = st; cfg_size = sz; cfg_attr = at;
        cyc_valid = 0;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic cyc(input logic [31:0] a, input bit d, input bit r, input bit l);
        @(negedge clk);
        cfg_we = 0;
        cyc_valid = 1; cyc_addr = a; cyc_dram_hit = d; cyc_rom_hit = r; cyc_lb_claim = l;
        @(negedge clk);
        cyc_valid = 0;
    endtask

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset windows have no effect
        cur_req = "R1";
        cyc(32'h0000_0000, 1, 0, 0);
        cyc(32'h0000_8000, 0, 1, 0);
        // R11: write and cycle at the same edge use old settings, the next uses new
        cur_req = "R11";
        @(negedge clk);
        cfg_we = 1; cfg_sel = 0; cfg_start = 13'h0010; cfg_size = 4'd4; cfg_attr = 3'b010;
        cyc_valid = 1; cyc_addr = 32'h0010_0000; cyc_dram_hit = 1; cyc_rom_hit = 0; cyc_lb_claim = 0;
        @(negedge clk);
        cfg_we = 0;
        @(negedge clk);
        cyc_valid = 0;
        // R2: 1M window boundaries
        cur_req = "R2";
        cyc(32'h001F_FFFF, 1, 0, 0);
        cyc(32'h0020_0000, 1, 0, 0);
        cyc(32'h000F_FFFF, 1, 0, 0);
        wr(1, 13'h0003, 4'd0, 3'b100);
        cyc(32'h0003_FFFF, 1, 0, 0);
        cyc(32'h0004_0000, 1, 0, 0);
        cyc(32'h0002_FFFF, 1, 0, 0);
        wr(1, 13'h0800, 4'd11, 3'b100);
        cyc(32'h0FFF_FFFF, 1, 0, 0);
        cyc(32'h0800_0000, 0, 0, 0);
        cyc(32'h07FF_FFFF, 1, 0, 0);
        // R3: aliases every 256MB, A31 still compared
        cur_req = "R3";
        wr(1, 13'h0010, 4'd4, 3'b100);
        cyc(32'h1010_0000, 1, 0, 0);
        cyc(32'h7018_0000, 1, 0, 0);
        cyc(32'h8010_0000, 0, 0, 0);
        cyc(32'hF010_0000, 0, 1, 0);
        // R4: reserved size codes disable
        cur_req = "R4";
        for (int s = 12; s < 16; s++) begin
            wr(1, 13'h0010, 4'(s), 3'b101);
            cyc(32'h0010_0000, 1, 0, 0);
        end
        // R5: hole with and without DRAM hit
        cur_req = "R5";
        wr(1, 13'h0000, 4'd0, 3'b000);
        cyc(32'h0010_0000, 0, 1, 0);
        cyc(32'h0010_0000, 0, 0, 0);
        cyc(32'h0010_0000, 1, 1, 0);
        // R6: force wins over DRAM and ROM
        cur_req = "R6";
        wr(1, 13'h0200, 4'd5, 3'b100);
        cyc(32'h0210_0000, 1, 0, 0);
        cyc(32'h0210_0000, 0, 1, 0);
        // R7: OR of two windows
        cur_req = "R7";
        wr(0, 13'h0200, 4'd6, 3'b001);
        cyc(32'h0210_0000, 1, 0, 0);
        cyc(32'h0230_0000, 1, 0, 0);
        wr(1, 13'h0000, 4'd15, 3'b000);
        cyc(32'h0200_0000, 1, 0, 0);
        cyc(32'h0400_0000, 1, 0, 0);
        // R8: plain priority
        cur_req = "R8";
        wr(0, 13'h0000, 4'd0, 3'b000);
        cyc(32'h0050_0000, 1, 1, 0);
        cyc(32'h0050_0000, 0, 1, 0);
        cyc(32'h0050_0000, 0, 0, 0);
        @(negedge clk); cyc_valid = 0; cyc_dram_hit = 1; cyc_rom_hit = 1; cyc_lb_claim = 1;
        @(negedge clk); cyc_dram_hit = 0; cyc_rom_hit = 0; cyc_lb_claim = 0;
        // R9: claim during ROM
        cur_req = "R9";
        cyc(32'hFFFF_0000, 0, 1, 1);
        cyc(32'h000F_0000, 1, 1, 1);
        // R10: high half never DRAM
        cur_req = "R10";
        cyc(32'h8000_0000, 1, 0, 0);
        cyc(32'hFFF0_0000, 1, 1, 0);
        // mixed traffic
        cur_req = "R8";
        lfsr = 32'hACE1_2345;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (lfsr[7:4] == 4'h3) wr(int'(lfsr[8]), lfsr[31:19], lfsr[12:9], lfsr[15:13]);
            else cyc({lfsr[31], 3'b000, lfsr[27:0]} ^ {lfsr[2:0], 29'h0}, lfsr[3], lfsr[16], lfsr[17] & lfsr[18]);
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule